// File: doc/BRIEF.md
# Opcode-Selected 8-bit Function Unit

The unit takes two operands, A and B, and a 5-bit operation code. From these it produces an 8-bit result, a ninth extension bit and a 16-bit wide bus. The codes cover four arithmetic functions, the bitwise logic family (including invert and pass-through), a count of ones and a parity over the 16-bit word {A,B}, and a magnitude compare that returns a one-hot code. Only the arithmetic codes drive the extension bit. The wide bus carries the full product during multiplication.

Any code outside the supported set drives every output to zero. The parameter `OUT_REG` adds one register stage on all outputs, and it is set by default. With the stage enabled, a result appears on the outputs one clock after its inputs are applied, and reset clears the outputs to zero. With `OUT_REG` cleared, the unit is purely combinational.

Top module: `opsel_alu`

## Requirements
- R1: Code 0: the result is (A+B) mod 256 and the extension bit is the carry out.
- R2: Code 1: the result is (A-B) mod 256 and the extension bit is 1 exactly when A < B (unsigned).
- R3: Code 2: the wide bus is the 16-bit product A*B, the result is its bits 7:0 and the extension bit is its bit 8. For every other code the wide bus is zero.
- R4: Code 3: when B is nonzero, the result is floor(A/B) and the extension bit is 0. When B is zero, the result is 0xFF and the extension bit is 1.
- R5: Codes 4, 5, 7, 8, 9 and 10 give the bitwise AND, OR, NOR, NAND, XOR and XNOR of A and B.
- R6: Code 6 gives ~A and code 11 gives A. The value of B has no effect on either.
- R7: Code 13 gives the number of 1 bits in {A,B} (0 to 16) as an unsigned binary result.
- R8: Code 24 puts the XOR of all 16 bits of {A,B} on result bit 0, so bit 0 is 1 for an odd count of ones. Result bits 7:1 are 0.
- R9: Code 25 sets result bit 0 when A<B, bit 1 when A==B and bit 2 when A>B. Bits 7:3 are 0.
- R10: Every code other than 0 to 3 drives the extension bit to 0.
- R11: Every code not listed in R1 to R9 (12, 14 to 23, 26 to 31) drives the result, the extension bit and the wide bus to zero.
- R12: With OUT_REG set, all outputs change one clock edge after the inputs that produce them, and they read zero while rst_ni is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| a_i | input | 8 | Operand A |
| b_i | input | 8 | Operand B |
| op_i | input | 5 | Operation code |
| res_o | output | 8 | Result |
| ext_o | output | 1 | Extension bit (carry, borrow, product bit 8, divide-by-zero) |
| wide_o | output | 16 | Full multiply product, zero otherwise |

## Verification
The hardest cases to reach are the edges of the arithmetic codes, where the extension bit and the wide bus must move apart from the low result. Three stimuli target these edges:
- 0x10*0x10 makes the result zero while product bit 8 is set.
- 0xFF*0xFF sets high product bits but leaves bit 8 clear.
- A divide by zero must raise the extension bit with a saturated result.

The stimulus also sends all-ones and all-zeros words to the ones count and to the parity. It replays the invert and pass-through codes with two different B values to show that B is ignored. Finally, it walks the unsupported codes right after codes that leave nonzero values on the outputs, so a stale or leaked value is visible.

// File: rtl/opsel_alu_pkg.sv
package opsel_alu_pkg;
  localparam logic [4:0] OPC_ADD  = 5'd0;
  localparam logic [4:0] OPC_SUB  = 5'd1;
  localparam logic [4:0] OPC_MUL  = 5'd2;
  localparam logic [4:0] OPC_DIV  = 5'd3;
  localparam logic [4:0] OPC_AND  = 5'd4;
  localparam logic [4:0] OPC_OR   = 5'd5;
  localparam logic [4:0] OPC_INV  = 5'd6;
  localparam logic [4:0] OPC_NOR  = 5'd7;
  localparam logic [4:0] OPC_NAND = 5'd8;
  localparam logic [4:0] OPC_XOR  = 5'd9;
  localparam logic [4:0] OPC_XNOR = 5'd10;
  localparam logic [4:0] OPC_PASS = 5'd11;
  localparam logic [4:0] OPC_POP  = 5'd13;
  localparam logic [4:0] OPC_PAR  = 5'd24;
  localparam logic [4:0] OPC_CMP  = 5'd25;

  function automatic logic is_arith(logic [4:0] op);
    return op <= OPC_DIV;
  endfunction

  function automatic logic is_supported(logic [4:0] op);
    return (op <= OPC_PASS) || (op == OPC_POP) || (op == OPC_PAR) || (op == OPC_CMP);
  endfunction
endpackage

// File: rtl/opsel_alu_arith.sv
module opsel_alu_arith #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic [4:0]     op_i,
  output logic [W-1:0]   res_o,
  output logic           ext_o,
  output logic [2*W-1:0] prod_o
);
  import opsel_alu_pkg::*;

  logic [W:0]     sum, dif;
  logic [2*W-1:0] prod;
  logic [W-1:0]   quo, safe_div;
  logic           div_zero;

  assign sum      = {1'b0, a_i} + {1'b0, b_i};
  assign dif      = {1'b0, a_i} - {1'b0, b_i};
  assign prod     = {{W{1'b0}}, a_i} * {{W{1'b0}}, b_i};
  assign div_zero = (b_i == '0);
  assign safe_div = div_zero ? {{(W-1){1'b0}}, 1'b1} : b_i;
  assign quo      = a_i / safe_div;

  always_comb begin
    res_o  = '0;
    ext_o  = 1'b0;
    prod_o = '0;
    case (op_i)
      OPC_ADD: begin res_o = sum[W-1:0]; ext_o = sum[W]; end
      OPC_SUB: begin res_o = dif[W-1:0]; ext_o = dif[W]; end
      OPC_MUL: begin res_o = prod[W-1:0]; ext_o = prod[W]; prod_o = prod; end
      OPC_DIV: begin res_o = div_zero ? {W{1'b1}} : quo; ext_o = div_zero; end
      default: ;
    endcase
  end
endmodule

// File: rtl/opsel_alu_logic.sv
module opsel_alu_logic #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [4:0]   op_i,
  output logic [W-1:0] res_o
);
  import opsel_alu_pkg::*;

  always_comb begin
    case (op_i)
      OPC_AND:  res_o = a_i & b_i;
      OPC_OR:   res_o = a_i | b_i;
      OPC_INV:  res_o = ~a_i;
      OPC_NOR:  res_o = ~(a_i | b_i);
      OPC_NAND: res_o = ~(a_i & b_i);
      OPC_XOR:  res_o = a_i ^ b_i;
      OPC_XNOR: res_o = ~(a_i ^ b_i);
      OPC_PASS: res_o = a_i;
      default:  res_o = '0;
    endcase
  end
endmodule

// File: rtl/opsel_alu_wide.sv
module opsel_alu_wide #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [4:0]   op_i,
  output logic [W-1:0] res_o
);
  import opsel_alu_pkg::*;

  localparam int unsigned WW    = 2 * W;
  localparam int unsigned CNT_W = $clog2(WW + 1);

  logic [WW-1:0]    word;
  logic [CNT_W-1:0] ones;
  logic             par;
  logic [2:0]       cmp;

  assign word = {a_i, b_i};

  always_comb begin
    ones = '0;
    for (int i = 0; i < WW; i++) ones = ones + CNT_W'(word[i]);
  end

  assign par = ^word;
  assign cmp = {a_i > b_i, a_i == b_i, a_i < b_i};

  always_comb begin
    res_o = '0;
    case (op_i)
      OPC_POP: res_o = W'(ones);
      OPC_PAR: res_o = {{(W-1){1'b0}}, par};
      OPC_CMP: res_o = {{(W-3){1'b0}}, cmp};
      default: ;
    endcase
  end
endmodule

// File: rtl/opsel_alu.sv
module opsel_alu #(
  parameter int unsigned DATA_W  = 8,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [DATA_W-1:0]   a_i,
  input  logic [DATA_W-1:0]   b_i,
  input  logic [4:0]          op_i,
  output logic [DATA_W-1:0]   res_o,
  output logic                ext_o,
  output logic [2*DATA_W-1:0] wide_o
);
  import opsel_alu_pkg::*;

  localparam int unsigned WW = 2 * DATA_W;

  logic [DATA_W-1:0] ar_res, lg_res, wd_res, nxt_res;
  logic              ar_ext, nxt_ext;
  logic [WW-1:0]     ar_prod, nxt_wide;

  opsel_alu_arith #(.W(DATA_W)) u_arith (
    .a_i(a_i), .b_i(b_i), .op_i(op_i),
    .res_o(ar_res), .ext_o(ar_ext), .prod_o(ar_prod)
  );

  opsel_alu_logic #(.W(DATA_W)) u_logic (
    .a_i(a_i), .b_i(b_i), .op_i(op_i), .res_o(lg_res)
  );

  opsel_alu_wide #(.W(DATA_W)) u_wide (
    .a_i(a_i), .b_i(b_i), .op_i(op_i), .res_o(wd_res)
  );

  // each unit returns zero outside its own codes
  assign nxt_res  = ar_res | lg_res | wd_res;
  assign nxt_ext  = ar_ext;
  assign nxt_wide = ar_prod;

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        res_o  <= '0;
        ext_o  <= 1'b0;
        wide_o <= '0;
      end else begin
        res_o  <= nxt_res;
        ext_o  <= nxt_ext;
        wide_o <= nxt_wide;
      end
    end

    p_unsup_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && !is_supported($past(op_i))) |-> (res_o == '0 && !ext_o && wide_o == '0));
    p_ext_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && !is_arith($past(op_i))) |-> !ext_o);
    p_div_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && $past(op_i) == OPC_DIV && $past(b_i) == '0) |-> (ext_o && res_o == '1));
    p_cmp_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && $past(op_i) == OPC_CMP) |-> ($onehot(res_o[2:0]) && res_o[DATA_W-1:3] == '0));
    p_wide_only_mul_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && $past(op_i) != OPC_MUL) |-> (wide_o == '0));
    p_mul_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && $past(op_i) == OPC_MUL) |-> (wide_o[DATA_W:0] == {ext_o, res_o}));
  end else begin : g_comb
    assign res_o  = nxt_res;
    assign ext_o  = nxt_ext;
    assign wide_o = nxt_wide;

    p_unsup_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !is_supported(op_i) |-> (res_o == '0 && !ext_o && wide_o == '0));
    p_ext_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !is_arith(op_i) |-> !ext_o);
    p_div_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i == OPC_DIV && b_i == '0) |-> (ext_o && res_o == '1));
    p_cmp_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op_i == OPC_CMP) |-> $onehot(res_o[2:0]));
  end
endmodule

// File: tb/opsel_alu_tb_top.sv
module opsel_alu_tb_top;
  localparam int CLK_P = 10;

  typedef struct {
    logic [7:0]  res;
    logic        ext;
    logic [15:0] wide;
    logic [4:0]  op;
    string       req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  a = '0, b = '0;
  logic [4:0]  op = '0;
  logic [7:0]  res;
  logic        ext;
  logic [15:0] wide;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;
  item_t exp_q[$];

  always #(CLK_P/2) clk = ~clk;

  opsel_alu #(.DATA_W(8), .OUT_REG(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .op_i(op),
    .res_o(res), .ext_o(ext), .wide_o(wide)
  );

  function automatic item_t model(logic [7:0] x, logic [7:0] y, logic [4:0] c, string r);
    item_t it;
    int s;
    it.res = 0; it.ext = 0; it.wide = 0; it.op = c; it.req = r;
    case (c)
      0:  begin s = x + y; it.res = s[7:0]; it.ext = s > 255; end
      1:  begin it.res = x - y; it.ext = x < y; end
      2:  begin it.wide = x * y; it.res = it.wide[7:0]; it.ext = it.wide[8]; end
      3:  if (y == 0) begin it.res = 8'hFF; it.ext = 1; end else it.res = x / y;
      4:  it.res = x & y;
      5:  it.res = x | y;
      6:  it.res = ~x;
      7:  it.res = ~(x | y);
      8:  it.res = ~(x & y);
      9:  it.res = x ^ y;
      10: it.res = ~(x ^ y);
      11: it.res = x;
      13: begin s = 0; for (int i = 0; i < 8; i++) s += x[i] + y[i]; it.res = 8'(s); end
      24: it.res = {7'b0, ^{x, y}};
      25: it.res = (x < y) ? 8'd1 : (x == y) ? 8'd2 : 8'd4;
      default: ;
    endcase
    return it;
  endfunction

  task automatic drive(logic [7:0] x, logic [7:0] y, logic [4:0] c, string r);
    @(negedge clk);
    a = x; b = y; op = c;
    exp_q.push_back(model(x, y, c, r));
  endtask

  // monitor: the registered result is visible a quarter period after the capturing edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (exp_q.size() > 0) begin
        item_t e;
        e = exp_q.pop_front();
        compared++;
        if (res !== e.res || ext !== e.ext || wide !== e.wide) begin
          mismatched++;
          $display("FAIL %s op=%0d res=%h/%h ext=%b/%b wide=%h/%h (actual/expected)",
                   e.req, e.op, res, e.res, ext, e.ext, wide, e.wide);
        end
      end
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    a = 8'hA5; b = 8'h3C; op = 5'd0;
    repeat (3) @(negedge clk);
    compared++;  // R12 reset state
    if (res !== 0 || ext !== 0 || wide !== 0) begin
      mismatched++;
      $display("FAIL R12 reset res=%h ext=%b wide=%h expected 0", res, ext, wide);
    end
    rst_n = 1'b1;
    // R1
    drive(8'h12, 8'h34, 0, "R1");
    drive(8'hFF, 8'h01, 0, "R1");
    drive(8'h80, 8'h80, 0, "R1");
    // R2
    drive(8'h50, 8'h20, 1, "R2");
    drive(8'h20, 8'h50, 1, "R2");
    drive(8'h33, 8'h33, 1, "R2");
    // R3
    drive(8'h10, 8'h10, 2, "R3");
    drive(8'hFF, 8'hFF, 2, "R3");
    drive(8'h07, 8'h09, 2, "R3");
    // R4
    drive(8'hC8, 8'h07, 3, "R4");
    drive(8'h05, 8'h00, 3, "R4");
    drive(8'h03, 8'h09, 3, "R4");
    // R5
    for (int c = 4; c <= 10; c++) if (c != 6) begin
      drive(8'hC3, 8'hA5, 5'(c), "R5");
      drive(8'h0F, 8'hFF, 5'(c), "R5");
    end
    // R6: B must not matter
    drive(8'h5A, 8'h00, 6, "R6");
    drive(8'h5A, 8'hFF, 6, "R6");
    drive(8'h5A, 8'h00, 11, "R6");
    drive(8'h5A, 8'h77, 11, "R6");
    // R7
    drive(8'hFF, 8'hFF, 13, "R7");
    drive(8'h00, 8'h00, 13, "R7");
    drive(8'h81, 8'h70, 13, "R7");
    // R8
    drive(8'h01, 8'h00, 24, "R8");
    drive(8'hFF, 8'hFF, 24, "R8");
    drive(8'h07, 8'h00, 24, "R8");
    // R9
    drive(8'h10, 8'h20, 25, "R9");
    drive(8'h20, 8'h20, 25, "R9");
    drive(8'hFE, 8'h01, 25, "R9");
    // R10 and R11: unsupported codes right after nonzero outputs
    for (int c = 12; c < 32; c++) begin
      drive(8'hFF, 8'hFF, 2, "R3");
      drive(8'hFF, 8'hFF, 5'(c), (c == 13 || c == 24 || c == 25) ? "R10" : "R11");
    end
    drive(8'h00, 8'h00, 12, "R11");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule